// File: doc/BRIEF.md
# Trigger Event Status Recorder

This block turns fast and slow trigger pulses into a numbered stream of events for acquisition software. When triggering is enabled and no event is in progress, a trigger starts an event. The block drives an active-low event clock low for a fixed number of system clocks. It also writes one status byte into a 16-entry FIFO. That byte records the low four bits of the event sequence counter, which trigger types fired, and whether the event came in before the host acknowledged the previous one. A separate 32-bit counter counts every trigger that arrives while enabled, including triggers that land while an event clock is already running.

The host reaches the block over a simple 32-bit bus with chip select, read and write strobes, and one address bit. A write carries a command byte in its least significant byte. Bit 0 enables triggering and bit 1 acknowledges the current event. A read with the address bit low pops the status FIFO and returns the byte with a live empty flag merged into bit 7. A read with the address bit high returns the trigger counter.

Top module: `trig_status_recorder`

## Requirements
- R1: After reset the event clock output is high, a status read returns 0x00000080 (empty), and a counter read returns 0.
- R2: A write takes the command from wdata bits 7..0; bits 31..8 have no effect. Bit 0 = 1 sets the enable and bit 0 = 0 clears it. A write with bit 0 = 1 while disabled resets the trigger counter, the sequence counter and the pending-acknowledge state. The same write while already enabled leaves them unchanged.
- R3: While disabled, triggers start no event clock, push no status byte and leave the trigger counter unchanged.
- R4: An accepted trigger drives the event clock low starting in the next cycle, for exactly 2 cycles. A trigger is accepted when enabled and the event clock is high.
- R5: Each status byte has bits 3..0 equal to the sequence number (the first event after enabling is 0), bit 4 set for a slow trigger and bit 5 set for a fast trigger. A fast and a slow trigger in the same cycle give one event with both bits set.
- R6: Status bit 6 is set when the previous event has not been acknowledged by a write with bit 1 = 1. An acknowledge in the same cycle as the trigger counts as received.
- R7: A read with chip select and address bit 3 low returns {24'b0, empty, entry[6:0]} and pops one entry. When the FIFO is empty it returns 0x00000080 and pops nothing.
- R8: A read with address bit 3 high returns the 32-bit count of all triggers seen while enabled, including those that arrive while the event clock is low.
- R9: The FIFO holds 16 entries. A status byte pushed while it is full is discarded, and the stored entries are kept in order.
- R10: The sequence field wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_trig_i | input | 1 | Fast trigger pulse, sampled each cycle |
| slow_trig_i | input | 1 | Slow trigger pulse, sampled each cycle |
| cs_i | input | 1 | Host chip select |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| addr3_i | input | 1 | Address bit 3: 0 selects status, 1 selects counter |
| wdata_i | input | 32 | Host write data; command byte in bits 7..0 |
| rdata_o | output | 32 | Host read data, valid while cs_i and rd_i are high |
| evt_clk_n_o | output | 1 | Active-low event clock |
| evt_sync_o | output | 4 | Low four bits of the sequence counter |

## Verification
A wrong sequence counter or pending flag does not show until the next status byte is read back. The event's low nibble or bit 6 is then off, so each event is read shortly after it is triggered to catch the fault within a few cycles. A stuck busy timer shows as an event clock that is low for the wrong number of cycles. It also shows as a trigger counter that no longer agrees with the number of FIFO entries. FIFO pointer or level faults show in the empty bit and in the order of entries once the FIFO has been filled past its depth and drained.

// File: rtl/trs_pkg.sv
// Shared types for the trigger event status recorder.
// Assumes: the stored status word is 7 bits; bit 7 of the host byte is live.
package trs_pkg;
    localparam int SEQ_SHOWN = 4;

    typedef struct packed {
        logic                 early;   // event came before previous acknowledge
        logic                 fast;    // fast trigger fired
        logic                 slow;    // slow trigger fired
        logic [SEQ_SHOWN-1:0] seq;     // low bits of the sequence counter
    } status_t;

    localparam int STATUS_W = $bits(status_t);
endpackage

// File: rtl/trs_cmd_ctrl.sv
// Command decoder: holds the trigger enable and emits one-cycle clear and
// acknowledge pulses from the least significant byte of a host write.
// Assumes: wr_stb_i is high for one cycle per host write.
module trs_cmd_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb_i,
    input  logic [31:0] wdata_i,
    output logic        enable_o,
    output logic        clear_o,
    output logic        ack_o
);
    logic enable_q;
    logic unused_cmd_bits;

    // Upper bus bits and the remaining command bits carry no function here.
    assign unused_cmd_bits = ^{wdata_i[31:8], wdata_i[7:2]};

    // Clearing happens only on an off-to-on transition of the enable.
    assign clear_o = wr_stb_i && wdata_i[0] && !enable_q;
    assign ack_o   = wr_stb_i && wdata_i[1];

    // Enable register follows bit 0 of every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= 1'b0;
        else if (wr_stb_i)
            enable_q <= wdata_i[0];
    end

    assign enable_o = enable_q;

    a_r2_clear_enables: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> enable_o);
endmodule

// File: rtl/trs_event_gen.sv
// Event generator: accepts triggers, times the active-low event clock,
// numbers events, tracks the acknowledge handshake and counts all triggers.
// Assumes: trigger inputs are synchronous to clk; EVT_LOW >= 1.
module trs_event_gen
    import trs_pkg::*;
#(
    parameter int EVT_LOW = 2,
    parameter int CNT_W   = 32,
    parameter int SEQ_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             clear_i,
    input  logic             ack_i,
    input  logic             fast_i,
    input  logic             slow_i,
    output logic             evt_clk_n_o,
    output logic             push_o,
    output status_t          status_o,
    output logic [CNT_W-1:0] total_o,
    output logic [SEQ_SHOWN-1:0] seq_o
);
    localparam int TMR_W = (EVT_LOW > 1) ? $clog2(EVT_LOW) : 1;
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(EVT_LOW - 1);

    logic             evt_clk_n_q;
    logic [TMR_W-1:0] tmr_q;
    logic [SEQ_W-1:0] seq_q;
    logic [CNT_W-1:0] total_q;
    logic             pending_q;
    logic             push_q;
    status_t          status_q;
    logic             any_trig;
    logic             accept;
    logic             early;

    assign any_trig = fast_i || slow_i;
    assign accept   = enable_i && any_trig && evt_clk_n_q;
    // A same-cycle acknowledge retires the previous event first.
    assign early    = pending_q && !ack_i;

    // Event clock timer: low for EVT_LOW cycles after each accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_clk_n_q <= 1'b1;
            tmr_q       <= '0;
        end else if (accept) begin
            evt_clk_n_q <= 1'b0;
            tmr_q       <= TMR_LOAD;
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end else begin
            evt_clk_n_q <= 1'b1;
        end
    end

    // Sequence counter: advances once per accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            seq_q <= '0;
        else if (accept)
            seq_q <= seq_q + 1'b1;
    end

    // Trigger counter: every trigger while enabled, busy or not.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            total_q <= '0;
        else if (enable_i && any_trig)
            total_q <= total_q + 1'b1;
    end

    // Pending flag: set by an event, cleared by the host acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)
            pending_q <= 1'b0;
        else if (accept)
            pending_q <= 1'b1;
        else if (ack_i)
            pending_q <= 1'b0;
    end

    // Status capture: aligned with the falling edge of the event clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q   <= 1'b0;
            status_q <= '0;
        end else begin
            push_q <= accept;
            if (accept) begin
                status_q.early <= early;
                status_q.fast  <= fast_i;
                status_q.slow  <= slow_i;
                status_q.seq   <= seq_q[SEQ_SHOWN-1:0];
            end
        end
    end

    assign evt_clk_n_o = evt_clk_n_q;
    assign push_o      = push_q;
    assign status_o    = status_q;
    assign total_o     = total_q;
    assign seq_o       = seq_q[SEQ_SHOWN-1:0];

    a_r4_push_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        push_q |-> $fell(evt_clk_n_q));

    a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && evt_clk_n_q) |=> evt_clk_n_q);

    a_r8_total_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (total_q == $past(total_q) || total_q == $past(total_q) + 1'b1));

    generate
        if (EVT_LOW > 1) begin : g_hold
            a_r4_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(evt_clk_n_q) |=> !evt_clk_n_q);
        end
    endgenerate
endmodule

// File: rtl/trs_status_fifo.sv
// Status FIFO: DEPTH entries of WIDTH bits, read data visible at the head.
// A push while full is dropped and noted in a sticky flag; a pop while
// empty is ignored. Assumes DEPTH is a power of two.
module trs_status_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [LVL_W-1:0] level_q;
    logic             overflow_q;
    logic             push_ok;
    logic             pop_ok;

    assign empty_o = (level_q == '0);
    assign full_o  = (level_q == LVL_W'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign dout_o  = mem_q[rd_ptr_q];

    // Storage write: only accepted pushes reach the array.
    always_ff @(posedge clk) begin
        if (push_ok)
            mem_q[wr_ptr_q] <= din_i;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push_ok)
                wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop_ok)
                rd_ptr_q <= rd_ptr_q + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    // Sticky overflow: records that at least one status byte was lost.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow_q <= 1'b0;
        else if (push_i && full_o)
            overflow_q <= 1'b1;
    end

    always_comb begin
        a_r9_level_range: assert (!rst_n || level_q <= LVL_W'(DEPTH));
    end

    a_r9_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !pop_i) |=> (full_o && overflow_q == ($past(overflow_q) || $past(push_i))));

    a_r7_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/trig_status_recorder.sv
// Top level: wires the command decoder, event generator and status FIFO
// to a 32-bit chip-select bus. Address bit 3 picks status (0) or
// counter (1). Assumes single-cycle read and write strobes.
module trig_status_recorder #(
    parameter int FIFO_DEPTH = 16,
    parameter int EVT_LOW    = 2,
    parameter int SEQ_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fast_trig_i,
    input  logic        slow_trig_i,
    input  logic        cs_i,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic        addr3_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        evt_clk_n_o,
    output logic [3:0]  evt_sync_o
);
    import trs_pkg::*;

    localparam int CNT_W = 32;

    logic             wr_stb;
    logic             rd_any;
    logic             rd_status;
    logic             enable;
    logic             clear;
    logic             ack;
    logic             push;
    status_t          status_in;
    logic [STATUS_W-1:0] head;
    logic             empty;
    logic             full;
    logic [CNT_W-1:0] total;
    logic             unused_full;

    assign wr_stb      = cs_i && wr_i;
    assign rd_any      = cs_i && rd_i;
    assign rd_status   = rd_any && !addr3_i;
    assign unused_full = full;

    trs_cmd_ctrl u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (wr_stb),
        .wdata_i  (wdata_i),
        .enable_o (enable),
        .clear_o  (clear),
        .ack_o    (ack)
    );

    trs_event_gen #(
        .EVT_LOW (EVT_LOW),
        .CNT_W   (CNT_W),
        .SEQ_W   (SEQ_W)
    ) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable),
        .clear_i     (clear),
        .ack_i       (ack),
        .fast_i      (fast_trig_i),
        .slow_i      (slow_trig_i),
        .evt_clk_n_o (evt_clk_n_o),
        .push_o      (push),
        .status_o    (status_in),
        .total_o     (total),
        .seq_o       (evt_sync_o)
    );

    trs_status_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (STATUS_W)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (status_in),
        .pop_i   (rd_status),
        .dout_o  (head),
        .empty_o (empty),
        .full_o  (full)
    );

    // Host read mux: counter word or status byte with live empty flag.
    always_comb begin
        rdata_o = '0;
        if (rd_any) begin
            if (addr3_i)
                rdata_o = total;
            else
                rdata_o = {24'b0, empty, (empty ? {STATUS_W{1'b0}} : head)};
        end
    end

    a_r7_empty_popless: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && empty && !push) |=> empty);
endmodule

// File: tb/trig_status_recorder_test.sv
`timescale 1ns/100ps
module trig_status_recorder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast = 1'b0, slow = 1'b0;
    logic        cs = 1'b0, wr = 1'b0, rd = 1'b0, a3 = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        evt_n;
    logic [3:0]  sync;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] got;

    always #2.5 clk = ~clk;

    trig_status_recorder uut (
        .clk(clk), .rst_n(rst_n), .fast_trig_i(fast), .slow_trig_i(slow),
        .cs_i(cs), .wr_i(wr), .rd_i(rd), .addr3_i(a3), .wdata_i(wdata),
        .rdata_o(rdata), .evt_clk_n_o(evt_n), .evt_sync_o(sync));

    // {ack first, fast, slow, pad, expected status byte}
    localparam logic [11:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h20},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h51},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'h32},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h13},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h64},
        {1'b1, 1'b1, 1'b0, 1'b0, 8'h25}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_cmd(input logic [31:0] d);
        @(negedge clk); cs = 1; wr = 1; wdata = d;
        @(negedge clk); cs = 0; wr = 0; wdata = '0;
    endtask

    task automatic host_rd(input logic addr, output logic [31:0] d);
        @(negedge clk); cs = 1; rd = 1; a3 = addr;
        #1 d = rdata;
        @(negedge clk); cs = 0; rd = 0; a3 = 0;
    endtask

    // One trigger pulse, checking the event clock shape when expected.
    task automatic trig(input logic f, input logic s, input logic expect_evt, input string req);
        @(negedge clk); fast = f; slow = s;
        @(negedge clk); fast = 0; slow = 0;
        #1 chk(req, {31'b0, evt_n}, {31'b0, !expect_evt});
        @(negedge clk); #1 chk(req, {31'b0, evt_n}, {31'b0, !expect_evt});
        @(negedge clk); #1 chk(req, {31'b0, evt_n}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        #1 chk("R1 evt clk", {31'b0, evt_n}, 32'd1);
        host_rd(0, got); chk("R1 status", got, 32'h80);
        host_rd(1, got); chk("R1 count", got, 32'h0);

        // R2 enable, then table walk for R4 R5 R6 R7
        wr_cmd(32'h1);
        for (int i = 0; i < 6; i++) begin
            if (VEC[i][11]) wr_cmd(32'h3);
            trig(VEC[i][10], VEC[i][9], 1'b1, "R4 event clock");
            host_rd(0, got); chk("R5 R6 status byte", got, {24'b0, VEC[i][7:0]});
        end
        host_rd(1, got); chk("R8 count after table", got, 32'd6);

        // R8 trigger during busy event clock: counted, not recorded
        @(negedge clk); fast = 1;
        @(negedge clk); fast = 0; slow = 1; #1 chk("R4 busy low1", {31'b0, evt_n}, 32'd0);
        @(negedge clk); slow = 0; #1 chk("R4 busy low2", {31'b0, evt_n}, 32'd0);
        @(negedge clk); #1 chk("R4 busy high", {31'b0, evt_n}, 32'd1);
        host_rd(1, got); chk("R8 busy counted", got, 32'd8);
        host_rd(0, got); chk("R6 busy entry", got, 32'h66);
        host_rd(0, got); chk("R7 empty after pop", got, 32'h80);

        // R6 acknowledge in the same cycle as the trigger
        @(negedge clk); cs = 1; wr = 1; wdata = 32'h3; fast = 1;
        @(negedge clk); cs = 0; wr = 0; wdata = '0; fast = 0;
        repeat (2) @(negedge clk);
        host_rd(0, got); chk("R6 same-cycle ack", got, 32'h27);

        // R9 R10 overflow and wrap
        for (int i = 0; i < 17; i++) trig(1'b1, 1'b0, 1'b1, "R4 burst");
        for (int i = 0; i < 16; i++) begin
            host_rd(0, got);
            chk("R9 R10 ordered entry", got, {24'b0, 4'h6, 4'((8 + i) & 15)});
        end
        host_rd(0, got); chk("R9 extra dropped", got, 32'h80);
        host_rd(1, got); chk("R8 count after burst", got, 32'd26);

        // R3 disabled triggers ignored
        wr_cmd(32'h0);
        trig(1'b1, 1'b1, 1'b0, "R3 no event clock");
        host_rd(1, got); chk("R3 count unchanged", got, 32'd26);
        host_rd(0, got); chk("R3 nothing pushed", got, 32'h80);

        // R2 re-enable clears counters; repeat enable does not
        wr_cmd(32'h1);
        host_rd(1, got); chk("R2 cleared count", got, 32'd0);
        trig(1'b1, 1'b0, 1'b1, "R4 after enable");
        host_rd(0, got); chk("R2 R5 seq restart", got, 32'h20);
        wr_cmd(32'hFFFF_FF01);
        host_rd(1, got); chk("R2 no clear when enabled", got, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule